// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns one virtual address into a 64-bit page entry by reading a four-level radix tree of 8-byte entries from memory. A request is accepted on a single-cycle `start_i` pulse. That pulse carries the virtual address, a table root address, a translation-enable flag and the size of physical memory. When translation is on, the walker reads one entry per level through a simple request/response port, with at most one read in flight. It stops at the first leaf, at the first invalid entry, at an address beyond memory, or after the last level. A `done_o` pulse then presents the result on `pte_o`. Bit 1 of a returned entry set means the translation succeeded. Every failed walk returns all zeros.

When a leaf is found above the last level, the walker widens it so that a cache holding one 4 KiB page per slot can use it unchanged. The virtual page bits that lie below that level are ORed into the physical page number field. When translation is off and the address lies inside memory, the result is an identity entry. Otherwise the result is zero.

The controller has four states:
- IDLE: waiting for a request.
- ISSUE: the entry address is formed and checked against the memory size.
- WAIT: a read is in flight.
- FINISH: the one-cycle result pulse.

The transitions between them are:
- ACCEPT (IDLE to ISSUE): a request arrives with translation on.
- BYPASS (IDLE to FINISH): a request arrives with translation off.
- FETCH (ISSUE to WAIT): the entry address is inside memory and a read is issued.
- REJECT (ISSUE to FINISH): the entry address is outside memory.
- DESCEND (WAIT to ISSUE): the returned entry is a table pointer and levels remain.
- RESOLVE (WAIT to FINISH): the returned entry is a leaf or invalid, or the last level has been read.
- RETIRE (FINISH to IDLE): the result has been presented.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is active and after its release with no request, `busy_o`, `done_o` and `rd_req_o` are 0.
- R2: With `xlat_en_i` low, the walk issues no read and `done_o` pulses on the cycle after the accepting edge. If `vaddr_i` < `mem_size_i`, `pte_o` is the address with bits 11:0 cleared, ORed with 0x3F2 (leaf bit 1 and permission bits 9:4). Otherwise `pte_o` is zero.
- R3: At level L (0 to 3, starting at 0), the shift is 27-9L. The read address is base + 8*((vaddr >> (12+shift)) & 0x1FF). The level-0 base is `base_i` with bits 11:0 cleared.
- R4: If a computed entry address is greater than or equal to `mem_size_i`, no read is issued and the result is zero.
- R5: A returned entry with bit 1 set ends the walk. The result is that entry ORed with ((vaddr >> 12) & ((1<<shift)-1)) << 12. Bit 1 takes priority over bit 0.
- R6: A returned entry with bits 1 and 0 both clear ends the walk with a zero result.
- R7: A returned entry with bit 0 set and bit 1 clear makes the next level's base that entry with bits 11:0 cleared.
- R8: If the level-3 entry is a table pointer, the walk ends with a zero result.
- R9: `rd_req_o` is a one-cycle pulse, and no new request is issued until `rd_valid_i` has returned data for the previous one.
- R10: `busy_o` stays high from the cycle after the accepting edge through the `done_o` cycle. `done_o` is a one-cycle pulse with the result on `pte_o`. Both outputs are low on the cycle after `done_o`.
- R11: A `start_i` pulse while `busy_o` is high is ignored. The current result is unchanged, and no further walk follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| vaddr_i | input | 64 | Virtual address to resolve |
| base_i | input | 64 | Root table address; low 12 bits ignored |
| xlat_en_i | input | 1 | 1 = walk the tables, 0 = identity mapping |
| mem_size_i | input | 64 | Bytes of physical memory; bound for entry reads |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | 64 | Byte address of the entry to read |
| rd_valid_i | input | 1 | Read data valid, one pulse per request |
| rd_data_i | input | 64 | Entry returned by memory |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Result pulse |
| pte_o | output | 64 | Resulting page entry, valid with `done_o` |

## Verification
The assertions assume that memory answers each read with exactly one `rd_valid_i` pulse and never raises it unprompted. They also assume that the inputs matter only on the accepting edge. The bench's memory model keeps to these rules: it returns one response per observed request, after a delay of 0 to 3 cycles chosen per walk, and it changes the request inputs right after acceptance. That change shows the values are latched. Stray `start_i` pulses are injected only while a walk is busy.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } walk_state_e;

    localparam int TABLE_FLAG_BIT = 0;
    localparam int LEAF_FLAG_BIT  = 1;
    localparam int PERM_LSB       = 4;
    localparam int PERM_COUNT     = 6;
endpackage

// File: rtl/pgwalk_index.sv
module pgwalk_index #(
    parameter int XLEN     = 64,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [XLEN-1:0]  vaddr_i,
    input  logic [XLEN-1:0]  base_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [XLEN-1:0]  ent_addr_o
);
    localparam int ENT_SH = $clog2(XLEN / 8);

    logic [IDX_W-1:0] idx_arr [LEVELS];
    logic             unused_va;

    for (genvar l = 0; l < LEVELS; l++) begin : g_idx
        localparam int SH = PG_SHIFT + (LEVELS - 1 - l) * IDX_W;
        assign idx_arr[l] = IDX_W'(vaddr_i >> SH);
    end

    assign ent_addr_o = base_i + (XLEN'(idx_arr[level_i]) << ENT_SH);
    assign unused_va  = ^vaddr_i;
endmodule

// File: rtl/pgwalk_leaf.sv
module pgwalk_leaf #(
    parameter int XLEN     = 64,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [XLEN-1:0]  entry_i,
    input  logic [XLEN-1:0]  vaddr_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             is_leaf_o,
    output logic             is_table_o,
    output logic [XLEN-1:0]  leaf_pte_o
);
    import pgwalk_pkg::*;

    logic [XLEN-1:0] fill [LEVELS];

    for (genvar l = 0; l < LEVELS; l++) begin : g_fill
        localparam int SH = (LEVELS - 1 - l) * IDX_W;
        assign fill[l] = ((vaddr_i >> PG_SHIFT) & ((XLEN'(1) << SH) - XLEN'(1))) << PG_SHIFT;
    end

    assign is_leaf_o  = entry_i[LEAF_FLAG_BIT];
    assign is_table_o = entry_i[TABLE_FLAG_BIT];
    assign leaf_pte_o = entry_i | fill[level_i];
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int XLEN     = 64,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] vaddr_i,
    input  logic [XLEN-1:0] base_i,
    input  logic            xlat_en_i,
    input  logic [XLEN-1:0] mem_size_i,
    output logic            rd_req_o,
    output logic [XLEN-1:0] rd_addr_o,
    input  logic            rd_valid_i,
    input  logic [XLEN-1:0] rd_data_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] pte_o
);
    import pgwalk_pkg::*;

    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [XLEN-1:0] PG_MASK     = (XLEN'(1) << PG_SHIFT) - XLEN'(1);
    localparam logic [XLEN-1:0] IDENT_FLAGS =
        (((XLEN'(1) << PERM_COUNT) - XLEN'(1)) << PERM_LSB) | (XLEN'(1) << LEAF_FLAG_BIT);
    localparam logic [LVL_W-1:0] LAST_LVL   = LVL_W'(LEVELS - 1);

    walk_state_e      state_q, state_d;
    logic [XLEN-1:0]  vaddr_q, base_q, msize_q, result_q;
    logic [LVL_W-1:0] level_q;
    logic [XLEN-1:0]  ent_addr, leaf_pte;
    logic             is_leaf, is_table, in_range, last_lvl, walk_ends;

    pgwalk_index #(.XLEN(XLEN), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT)) u_index (
        .vaddr_i    (vaddr_q),
        .base_i     (base_q),
        .level_i    (level_q),
        .ent_addr_o (ent_addr)
    );

    pgwalk_leaf #(.XLEN(XLEN), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT)) u_leaf (
        .entry_i    (rd_data_i),
        .vaddr_i    (vaddr_q),
        .level_i    (level_q),
        .is_leaf_o  (is_leaf),
        .is_table_o (is_table),
        .leaf_pte_o (leaf_pte)
    );

    assign in_range  = ent_addr < msize_q;
    assign last_lvl  = level_q == LAST_LVL;
    assign walk_ends = is_leaf || !is_table || last_lvl;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, BYPASS, FETCH, REJECT, DESCEND, RESOLVE, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = xlat_en_i ? ST_ISSUE : ST_FINISH;
            ST_ISSUE:  state_d = in_range ? ST_WAIT : ST_FINISH;
            ST_WAIT:   if (rd_valid_i) state_d = walk_ends ? ST_FINISH : ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Walk context and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q  <= '0;
            base_q   <= '0;
            msize_q  <= '0;
            level_q  <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    vaddr_q  <= vaddr_i;
                    base_q   <= base_i & ~PG_MASK;
                    msize_q  <= mem_size_i;
                    level_q  <= '0;
                    result_q <= (!xlat_en_i && (vaddr_i < mem_size_i))
                                ? ((vaddr_i & ~PG_MASK) | IDENT_FLAGS) : '0;
                end
                ST_ISSUE: if (!in_range) result_q <= '0;
                ST_WAIT: if (rd_valid_i) begin
                    if (is_leaf)                    result_q <= leaf_pte;
                    else if (!is_table || last_lvl) result_q <= '0;
                    else begin
                        base_q  <= rd_data_i & ~PG_MASK;
                        level_q <= level_q + LVL_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_req_o  = (state_q == ST_ISSUE) && in_range;
        rd_addr_o = ent_addr;
        busy_o    = state_q != ST_IDLE;
        done_o    = state_q == ST_FINISH;
        pte_o     = result_q;
    end

    // Read-in-flight tracker for the checks below
    logic rd_open_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_open_q <= 1'b0;
        else if (rd_req_o)   rd_open_q <= 1'b1;
        else if (rd_valid_i) rd_open_q <= 1'b0;
    end

    assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !rd_open_q);
    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    assert_fail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pte_o[LEAF_FLAG_BIT]) |-> (pte_o == '0));
    assert_bypass_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !xlat_en_i) |=> (done_o && !rd_req_o));
    assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(vaddr_q));
    assert_bound_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && !rd_req_o && !rd_open_q && (rd_addr_o >= msize_q) && xlat_en_seen_q)
        |=> (done_o && pte_o == '0));

    // Tracks whether the current walk uses translation (checker only)
    logic xlat_en_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  xlat_en_seen_q <= 1'b0;
        else if (start_i && !busy_o) xlat_en_seen_q <= xlat_en_i;
    end
endmodule

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [63:0] vaddr_i, base_i, mem_size_i;
    logic        xlat_en_i;
    logic        rd_req_o;
    logic [63:0] rd_addr_o;
    logic        rd_valid_i;
    logic [63:0] rd_data_i;
    logic        busy_o, done_o;
    logic [63:0] pte_o;

    int n_tests = 0;
    int n_fail  = 0;
    int lat_cfg = 0;

    logic [63:0] mem_q [longint unsigned];
    logic [63:0] exp_q [$];
    logic        pend;
    logic [63:0] pend_addr;
    int          pend_cnt;

    always #4 clk = ~clk;

    pgwalk_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .base_i(base_i), .xlat_en_i(xlat_en_i), .mem_size_i(mem_size_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .pte_o(pte_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rdmem(input logic [63:0] a);
        return mem_q.exists(a) ? mem_q[a] : 64'h0;
    endfunction

    function automatic logic [63:0] mkva(input int i0, input int i1, input int i2,
                                         input int i3, input int off);
        return (64'(i0) << 39) | (64'(i1) << 30) | (64'(i2) << 21) | (64'(i3) << 12) | 64'(off);
    endfunction

    // Behavioural reference built from the requirements
    task automatic ref_walk(input logic [63:0] va, input logic [63:0] base, input bit en,
                            input logic [63:0] ms, output logic [63:0] pte);
        logic [63:0] b, a, e;
        pte = 64'h0;
        if (!en) begin
            if (va < ms) pte = (va & ~64'hFFF) | 64'h3F2;
            return;
        end
        b = base & ~64'hFFF;
        for (int lv = 0; lv < 4; lv++) begin
            int sh;
            sh = 27 - 9 * lv;
            a  = b + 64'd8 * ((va >> (12 + sh)) & 64'h1FF);
            if (a >= ms) break;
            exp_q.push_back(a);
            e = rdmem(a);
            if (e[1]) begin
                pte = e | (((va >> 12) & ((64'd1 << sh) - 64'd1)) << 12);
                break;
            end
            if (!e[0]) break;
            b = e & ~64'hFFF;
        end
    endtask

    // Memory responder: one answer per request after lat_cfg cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_valid_i <= 1'b0;
            rd_data_i  <= 64'h0;
            pend       <= 1'b0;
            pend_addr  <= 64'h0;
            pend_cnt   <= 0;
        end else begin
            rd_valid_i <= 1'b0;
            if (pend) begin
                if (pend_cnt == 0) begin
                    rd_valid_i <= 1'b1;
                    rd_data_i  <= rdmem(pend_addr);
                    pend       <= 1'b0;
                end else pend_cnt <= pend_cnt - 1;
            end
            if (rd_req_o) begin
                chk(!pend, "R9", "request while a read is open", 64'(pend), 64'h0);
                if (exp_q.size() == 0)
                    chk(1'b0, "R3", "unexpected read address", rd_addr_o, 64'h0);
                else
                    chk(rd_addr_o == exp_q[0], "R3", "read address", rd_addr_o, exp_q[0]);
                if (exp_q.size() != 0) void'(exp_q.pop_front());
                pend      <= 1'b1;
                pend_addr <= rd_addr_o;
                pend_cnt  <= lat_cfg;
            end
        end
    end

    task automatic run_walk(input logic [63:0] va, input logic [63:0] base, input bit en,
                            input logic [63:0] ms, input int lat, input string tag,
                            input bit disturb);
        logic [63:0] ep;
        bit seen;
        int n;
        exp_q.delete();
        ref_walk(va, base, en, ms, ep);
        lat_cfg = lat;
        @(negedge clk);
        start_i = 1'b1; vaddr_i = va; base_i = base; xlat_en_i = en; mem_size_i = ms;
        @(negedge clk);
        start_i = 1'b0; vaddr_i = ~va; base_i = 64'h0; mem_size_i = 64'h0; xlat_en_i = ~en;
        seen = 1'b0;
        n = 0;
        while (!seen && n < 300) begin
            if (n > 0) @(negedge clk);
            chk(busy_o, "R10", {tag, " busy during walk"}, 64'(busy_o), 64'h1);
            if (!en && n == 0)
                chk(done_o, "R2", {tag, " done one cycle after start"}, 64'(done_o), 64'h1);
            if (disturb && n == 1) begin
                start_i = 1'b1; vaddr_i = va ^ 64'h1FF000; xlat_en_i = 1'b0;
                mem_size_i = 64'hFFFF_FFFF;
            end
            if (disturb && n == 2) start_i = 1'b0;
            if (done_o) begin
                seen = 1'b1;
                chk(pte_o == ep, tag, "result entry", pte_o, ep);
                chk(exp_q.size() == 0, "R3", {tag, " reads remaining"}, 64'(exp_q.size()), 64'h0);
            end
            n++;
        end
        if (!seen) chk(1'b0, "R10", {tag, " done never seen"}, 64'h0, 64'h1);
        start_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o, "R10", {tag, " idle after done"},
            {62'h0, busy_o, done_o}, 64'h0);
        if (disturb)
            chk(!busy_o, "R11", {tag, " no walk after ignored start"}, 64'(busy_o), 64'h0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    localparam logic [63:0] MS = 64'h10_0000;

    initial begin
        rst_n = 1'b0; start_i = 1'b0; vaddr_i = 0; base_i = 0; xlat_en_i = 0; mem_size_i = 0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !rd_req_o, "R1", "outputs in reset",
            {61'h0, busy_o, done_o, rd_req_o}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o && !rd_req_o, "R1", "outputs after reset",
            {61'h0, busy_o, done_o, rd_req_o}, 64'h0);

        // Four-level walk to a 4 KiB leaf
        mem_q[64'h1000 + 8*1] = 64'h2001;
        mem_q[64'h2000 + 8*2] = 64'h3001;
        mem_q[64'h3000 + 8*3] = 64'h4001;
        mem_q[64'h4000 + 8*4] = 64'h5555_53F2;
        // Leaf at level 1 (2^18 pages)
        mem_q[64'h1000 + 8*5] = 64'h5001;
        mem_q[64'h5000 + 8*7] = 64'h4000_00F2;
        // Leaf at level 0 (2^27 pages)
        mem_q[64'h1000 + 8*11] = 64'h8000_03F2;
        // Both flags set: leaf wins
        mem_q[64'h1000 + 8*12] = 64'hD0F3;
        // Invalid at level 2
        mem_q[64'h1000 + 8*6] = 64'h6001;
        mem_q[64'h6000 + 8*0] = 64'h7001;
        mem_q[64'h7000 + 8*9] = 64'h0000_0000_0000_0008;
        // Pointer at last level
        mem_q[64'h1000 + 8*8] = 64'h9001;
        mem_q[64'h9000 + 8*1] = 64'hA001;
        mem_q[64'hA000 + 8*1] = 64'hB001;
        mem_q[64'hB000 + 8*1] = 64'hC001;
        // Pointer beyond memory
        mem_q[64'h1000 + 8*10] = 64'h2000_0001;

        run_walk(mkva(1, 2, 3, 4, 'h123), 64'h1000, 1'b1, MS, 0, "R7 four-level 4K leaf", 1'b0);
        run_walk(mkva(1, 2, 3, 4, 'h7FF), 64'h1ABC, 1'b1, MS, 2, "R3 base low bits ignored", 1'b0);
        run_walk(mkva(5, 7, 'h1AB, 'h0CD, 9), 64'h1000, 1'b1, MS, 1, "R5 level-1 leaf fill", 1'b0);
        run_walk(mkva(11, 'h155, 'h0AA, 'h1FF, 7), 64'h1000, 1'b1, MS, 0, "R5 level-0 leaf fill", 1'b0);
        run_walk(mkva(12, 3, 4, 5, 0), 64'h1000, 1'b1, MS, 3, "R5 leaf bit priority", 1'b0);
        run_walk(mkva(6, 0, 9, 2, 0), 64'h1000, 1'b1, MS, 1, "R6 invalid entry", 1'b0);
        run_walk(mkva(8, 1, 1, 1, 0), 64'h1000, 1'b1, MS, 0, "R8 levels exhausted", 1'b0);
        run_walk(mkva(10, 4, 0, 0, 0), 64'h1000, 1'b1, MS, 0, "R4 pointer beyond memory", 1'b0);
        run_walk(mkva(1, 2, 3, 4, 0), MS, 1'b1, MS, 0, "R4 root beyond memory", 1'b0);
        run_walk(64'h0000_0000_000A_B123, 64'h1000, 1'b0, MS, 0, "R2 identity in range", 1'b0);
        run_walk(64'h0000_0000_0010_0000, 64'h1000, 1'b0, MS, 0, "R2 identity at bound", 1'b0);
        run_walk(64'hFFFF_0000_0000_0000, 64'h1000, 1'b0, MS, 0, "R2 identity far out", 1'b0);
        run_walk(mkva(1, 2, 3, 4, 'h044), 64'h1000, 1'b1, MS, 3, "R11 start ignored while busy", 1'b1);
        run_walk(mkva(5, 7, 0, 0, 0), 64'h1000, 1'b1, MS, 2, "R9 slow memory", 1'b0);

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule